// File: doc/BRIEF.md
# PWM Trip-Zone Output Override

This block sits between a PWM generator and the pins of one output pair, A and B. It watches a small set of external trip inputs and comparator results. For each output it builds two compare events by picking a "high" and a "low" source through a selector and applying a condition code. It can also take the general trip inputs directly. Any of these can be routed into one of two trip latches. The one-shot latch stays set until software clears it. The cycle-by-cycle latch is let go at the next counter-zero pulse, but only once its cause has gone away.

Routing and output action are configured on their own. Each output has three actions: one for the general trip (either latch active), one for event 1 and one for event 2. Each action is applied while its condition holds, whether or not that event is routed into a latch. When actions conflict, a fixed ladder decides: the general trip overrides event 1, and event 1 overrides event 2. An action coded "no action" defers to the next rung, so the PWM passes through when every active rung defers. Each event can take an asynchronous path, which acts in the same cycle, or a synchronized path, which adds one clock register.

Each trip latch is a two-state machine. The one-shot latch has state TRIP_CLEAR, which moves to TRIP_HELD when its routed source is active. From TRIP_HELD it returns to TRIP_CLEAR on a clear pulse with no source active. The cycle-by-cycle latch has the same two states and the same entry transition. From TRIP_HELD it returns to TRIP_CLEAR on a counter-zero pulse with no source active. While a latch's source is active, that latch counts as active even before the state register has moved. Sticky flags record one-shot, cycle-by-cycle and per-event activity until a flag clear.

Top module: `pwm_trip_override`

## Requirements
- R1: After reset both latches are in TRIP_CLEAR (trip_ost = trip_cbc = 0) and all flags are 0. With all actions 11 and no trip, each output equals its PWM input with its enable at 1.
- R2: Action codes are 00 = high-impedance (enable 0, pin value 0), 01 = force high, 10 = force low, and 11 = no action. A forced pin has its enable at 1.
- R3: Selector value 0 or 1 picks tz_in[0] or tz_in[1], and 2 or 3 picks cmp_in[0] or cmp_in[1]. Condition codes are 00 = off, 01 = selected high source is 0, 10 = selected high source is 1, 11 = selected low source is 0. Events 0 and 1 (A's event 1 and event 2) use the A selectors. Events 2 and 3 (B's event 1 and event 2) use the B selectors.
- R4: On output A, an active general trip with an action other than 11 wins. Otherwise an active event 1 with an action other than 11 wins. Otherwise an active event 2 with an action other than 11 wins. Otherwise the PWM passes through.
- R5: Output B follows the same ladder with act_tz_b, its own events and pwm_b_in.
- R6: An event whose evt_async bit is 1 changes the outputs in the same cycle as its input. An event with the bit at 0 changes them one clock edge later.
- R7: A routed one-shot source drives trip_ost to 1 from the next edge. The latch holds through any cycle without a clear pulse. A clear pulse given while no one-shot source is active returns trip_ost to 0 at the following edge.
- R8: A routed cycle-by-cycle source drives trip_cbc to 1 from the next edge. The latch holds until an edge on which cnt_zero is 1 and no cycle-by-cycle source is active, and returns to 0 at that edge.
- R9: Each trip input has a one-shot and a cycle-by-cycle route enable. Event 1 of each output can be routed only to the one-shot latch, and event 2 only to the cycle-by-cycle latch. An event's own action applies whether or not it is routed.
- R10: The flags flg_ost, flg_cbc and flg_evt (bits in event order 0..3) set one edge after their source is active. They stay set until flag_clr, and a source still active at the clear keeps its flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PWM clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pwm_a_in | input | 1 | PWM value for output A |
| pwm_b_in | input | 1 | PWM value for output B |
| tz_in | input | NTZ | External trip inputs, active high |
| cmp_in | input | NCMP | Comparator results |
| cnt_zero | input | 1 | Counter-zero pulse from the timebase |
| osht_clr | input | 1 | One-shot latch clear pulse |
| flag_clr | input | 1 | Sticky flag clear pulse |
| dca_hi_sel | input | SELW | Output A high source selector |
| dca_lo_sel | input | SELW | Output A low source selector |
| dcb_hi_sel | input | SELW | Output B high source selector |
| dcb_lo_sel | input | SELW | Output B low source selector |
| evt_cond | input | 8 | Condition code per event, event k at bits 2k+1:2k |
| evt_async | input | 4 | Asynchronous path select per event |
| tz_ost_en | input | NTZ | Route trip inputs to the one-shot latch |
| tz_cbc_en | input | NTZ | Route trip inputs to the cycle-by-cycle latch |
| e1_ost_en | input | 2 | Route event 1 of A (bit 0) or B (bit 1) to one-shot |
| e2_cbc_en | input | 2 | Route event 2 of A (bit 0) or B (bit 1) to cycle-by-cycle |
| act_tz_a | input | 2 | General trip action, output A |
| act_e1_a | input | 2 | Event 1 action, output A |
| act_e2_a | input | 2 | Event 2 action, output A |
| act_tz_b | input | 2 | General trip action, output B |
| act_e1_b | input | 2 | Event 1 action, output B |
| act_e2_b | input | 2 | Event 2 action, output B |
| pwm_a_out | output | 1 | Pin value A |
| pwm_a_oe | output | 1 | Pin enable A |
| pwm_b_out | output | 1 | Pin value B |
| pwm_b_oe | output | 1 | Pin enable B |
| trip_ost | output | 1 | One-shot latch state |
| trip_cbc | output | 1 | Cycle-by-cycle latch state |
| flg_ost | output | 1 | Sticky one-shot flag |
| flg_cbc | output | 1 | Sticky cycle-by-cycle flag |
| flg_evt | output | 4 | Sticky per-event flags |

## Verification
The bench builds the block with its defaults, NTZ = 2 and NCMP = 2. This gives a four-entry source selector in which every selector value lands on a real input, so both trip inputs and both comparators can serve as high or low sources for either output. A vector table walks the priority ladder on output A using combinations of two sources and the event actions. Directed tests then cover the latch hold and release rules, the timing of the synchronized path against the asynchronous one, routing without action and the reverse, output B, and flag clearing while a source is still active.

// File: rtl/pto_pkg.sv
package pto_pkg;
    typedef enum logic [1:0] {
        ACT_HIZ  = 2'b00,
        ACT_HIGH = 2'b01,
        ACT_LOW  = 2'b10,
        ACT_PASS = 2'b11
    } act_e;

    typedef enum logic [1:0] {
        COND_OFF     = 2'b00,
        COND_HI_LOW  = 2'b01,
        COND_HI_HIGH = 2'b10,
        COND_LO_LOW  = 2'b11
    } cond_e;

    typedef enum logic {
        TRIP_CLEAR = 1'b0,
        TRIP_HELD  = 1'b1
    } trip_st_e;

    localparam int NUM_EVT = 4;
    localparam int NUM_OUT = 2;
endpackage

// File: rtl/pto_dc_event.sv
module pto_dc_event
    import pto_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       hi_src,
    input  logic       lo_src,
    input  logic [1:0] cond,
    input  logic       use_async,
    output logic       evt
);
    logic raw;
    logic raw_q;

    always_comb begin
        unique case (cond_e'(cond))
            COND_OFF:     raw = 1'b0;
            COND_HI_LOW:  raw = ~hi_src;
            COND_HI_HIGH: raw = hi_src;
            COND_LO_LOW:  raw = ~lo_src;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) raw_q <= 1'b0;
        else        raw_q <= raw;
    end

    assign evt = use_async ? raw : raw_q;
endmodule

// File: rtl/pto_trip_latch.sv
module pto_trip_latch
    import pto_pkg::*;
#(
    parameter bit RELEASE_ON_ZERO = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic src,
    input  logic release_pulse,
    output logic held,
    output logic active
);
    trip_st_e state, state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= TRIP_CLEAR;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            TRIP_CLEAR: if (src) state_nx = TRIP_HELD;
            TRIP_HELD:  if (release_pulse && !src) state_nx = TRIP_CLEAR;
        endcase
    end

    always_comb begin
        held   = (state == TRIP_HELD);
        active = held | src;
    end
endmodule

// File: rtl/pto_out_resolve.sv
module pto_out_resolve
    import pto_pkg::*;
(
    input  logic       pwm_in,
    input  logic       trip_act,
    input  logic       evt1,
    input  logic       evt2,
    input  logic [1:0] act_tz,
    input  logic [1:0] act_e1,
    input  logic [1:0] act_e2,
    output logic       pin,
    output logic       oe
);
    act_e sel;

    always_comb begin
        sel = ACT_PASS;
        if (evt2 && act_e_t(act_e2) != ACT_PASS) sel = act_e_t(act_e2);
        if (evt1 && act_e_t(act_e1) != ACT_PASS) sel = act_e_t(act_e1);
        if (trip_act && act_e_t(act_tz) != ACT_PASS) sel = act_e_t(act_tz);
    end

    function automatic act_e act_e_t(input logic [1:0] v);
        return act_e'(v);
    endfunction

    always_comb begin
        unique case (sel)
            ACT_HIZ:  begin pin = 1'b0;   oe = 1'b0; end
            ACT_HIGH: begin pin = 1'b1;   oe = 1'b1; end
            ACT_LOW:  begin pin = 1'b0;   oe = 1'b1; end
            ACT_PASS: begin pin = pwm_in; oe = 1'b1; end
        endcase
    end
endmodule

// File: rtl/pwm_trip_override.sv
module pwm_trip_override
    import pto_pkg::*;
#(
    parameter int NTZ  = 2,
    parameter int NCMP = 2,
    localparam int NSRC = NTZ + NCMP,
    localparam int SELW = (NSRC > 1) ? $clog2(NSRC) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            pwm_a_in,
    input  logic            pwm_b_in,
    input  logic [NTZ-1:0]  tz_in,
    input  logic [NCMP-1:0] cmp_in,
    input  logic            cnt_zero,
    input  logic            osht_clr,
    input  logic            flag_clr,
    input  logic [SELW-1:0] dca_hi_sel,
    input  logic [SELW-1:0] dca_lo_sel,
    input  logic [SELW-1:0] dcb_hi_sel,
    input  logic [SELW-1:0] dcb_lo_sel,
    input  logic [7:0]      evt_cond,
    input  logic [3:0]      evt_async,
    input  logic [NTZ-1:0]  tz_ost_en,
    input  logic [NTZ-1:0]  tz_cbc_en,
    input  logic [1:0]      e1_ost_en,
    input  logic [1:0]      e2_cbc_en,
    input  logic [1:0]      act_tz_a,
    input  logic [1:0]      act_e1_a,
    input  logic [1:0]      act_e2_a,
    input  logic [1:0]      act_tz_b,
    input  logic [1:0]      act_e1_b,
    input  logic [1:0]      act_e2_b,
    output logic            pwm_a_out,
    output logic            pwm_a_oe,
    output logic            pwm_b_out,
    output logic            pwm_b_oe,
    output logic            trip_ost,
    output logic            trip_cbc,
    output logic            flg_ost,
    output logic            flg_cbc,
    output logic [3:0]      flg_evt
);
    logic [NSRC-1:0]    src_vec;
    logic [NUM_OUT-1:0] grp_hi, grp_lo;
    logic [NUM_EVT-1:0] evt_v;
    logic               ost_src, cbc_src, ost_act, cbc_act, trip_any;

    assign src_vec   = {cmp_in, tz_in};
    assign grp_hi[0] = src_vec[dca_hi_sel];
    assign grp_lo[0] = src_vec[dca_lo_sel];
    assign grp_hi[1] = src_vec[dcb_hi_sel];
    assign grp_lo[1] = src_vec[dcb_lo_sel];

    for (genvar k = 0; k < NUM_EVT; k++) begin : g_evt
        pto_dc_event u_evt (
            .clk       (clk),
            .rst_n     (rst_n),
            .hi_src    (grp_hi[k/2]),
            .lo_src    (grp_lo[k/2]),
            .cond      (evt_cond[2*k +: 2]),
            .use_async (evt_async[k]),
            .evt       (evt_v[k])
        );
    end

    assign ost_src = (|(tz_in & tz_ost_en)) | (evt_v[0] & e1_ost_en[0])
                   | (evt_v[2] & e1_ost_en[1]);
    assign cbc_src = (|(tz_in & tz_cbc_en)) | (evt_v[1] & e2_cbc_en[0])
                   | (evt_v[3] & e2_cbc_en[1]);

    pto_trip_latch #(.RELEASE_ON_ZERO(1'b0)) u_ost (
        .clk(clk), .rst_n(rst_n), .src(ost_src), .release_pulse(osht_clr),
        .held(trip_ost), .active(ost_act)
    );

    pto_trip_latch #(.RELEASE_ON_ZERO(1'b1)) u_cbc (
        .clk(clk), .rst_n(rst_n), .src(cbc_src), .release_pulse(cnt_zero),
        .held(trip_cbc), .active(cbc_act)
    );

    assign trip_any = ost_act | cbc_act;

    logic [NUM_OUT-1:0] pwm_in_v, pin_v, oe_v;
    logic [1:0]         a_tz [NUM_OUT];
    logic [1:0]         a_e1 [NUM_OUT];
    logic [1:0]         a_e2 [NUM_OUT];

    assign pwm_in_v = {pwm_b_in, pwm_a_in};
    assign a_tz[0] = act_tz_a; assign a_e1[0] = act_e1_a; assign a_e2[0] = act_e2_a;
    assign a_tz[1] = act_tz_b; assign a_e1[1] = act_e1_b; assign a_e2[1] = act_e2_b;

    for (genvar c = 0; c < NUM_OUT; c++) begin : g_out
        pto_out_resolve u_res (
            .pwm_in   (pwm_in_v[c]),
            .trip_act (trip_any),
            .evt1     (evt_v[2*c]),
            .evt2     (evt_v[2*c+1]),
            .act_tz   (a_tz[c]),
            .act_e1   (a_e1[c]),
            .act_e2   (a_e2[c]),
            .pin      (pin_v[c]),
            .oe       (oe_v[c])
        );
    end

    assign pwm_a_out = pin_v[0];
    assign pwm_a_oe  = oe_v[0];
    assign pwm_b_out = pin_v[1];
    assign pwm_b_oe  = oe_v[1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flg_ost <= 1'b0;
            flg_cbc <= 1'b0;
            flg_evt <= '0;
        end else if (flag_clr) begin
            flg_ost <= ost_src;
            flg_cbc <= cbc_src;
            flg_evt <= evt_v;
        end else begin
            flg_ost <= flg_ost | ost_src;
            flg_cbc <= flg_cbc | cbc_src;
            flg_evt <= flg_evt | evt_v;
        end
    end
endmodule

// File: rtl/pto_checker.sv
module pto_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       osht_clr,
    input logic       flag_clr,
    input logic       cnt_zero,
    input logic       ost_src,
    input logic       cbc_src,
    input logic       trip_ost,
    input logic       trip_cbc,
    input logic [1:0] act_tz_a,
    input logic       pwm_a_out,
    input logic       pwm_a_oe,
    input logic       pwm_b_out,
    input logic       pwm_b_oe,
    input logic       flg_ost,
    input logic       flg_cbc
);
    assert_hiz_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!pwm_a_oe |-> !pwm_a_out) and (!pwm_b_oe |-> !pwm_b_out));

    assert_tz_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((trip_ost || trip_cbc) && act_tz_a == 2'b10) |-> (pwm_a_oe && !pwm_a_out));

    assert_ost_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (trip_ost && !osht_clr) |=> trip_ost);

    assert_ost_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (trip_ost && osht_clr && !ost_src) |=> !trip_ost);

    assert_cbc_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (trip_cbc && !cnt_zero) |=> trip_cbc);

    assert_cbc_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (trip_cbc && cnt_zero && !cbc_src) |=> !trip_cbc);

    assert_flag_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ((flg_ost || flg_cbc) && !flag_clr) |=> (flg_ost || flg_cbc));
endmodule

bind pwm_trip_override pto_checker chk_i (
    .clk(clk), .rst_n(rst_n), .osht_clr(osht_clr), .flag_clr(flag_clr),
    .cnt_zero(cnt_zero), .ost_src(ost_src), .cbc_src(cbc_src),
    .trip_ost(trip_ost), .trip_cbc(trip_cbc), .act_tz_a(act_tz_a),
    .pwm_a_out(pwm_a_out), .pwm_a_oe(pwm_a_oe), .pwm_b_out(pwm_b_out),
    .pwm_b_oe(pwm_b_oe), .flg_ost(flg_ost), .flg_cbc(flg_cbc)
);

// File: tb/pwm_trip_override_tb_top.sv
`timescale 1ns/100ps
module pwm_trip_override_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pwm_a_in, pwm_b_in, cnt_zero, osht_clr, flag_clr;
    logic [1:0] tz_in, cmp_in;
    logic [1:0] dca_hi_sel, dca_lo_sel, dcb_hi_sel, dcb_lo_sel;
    logic [7:0] evt_cond;
    logic [3:0] evt_async;
    logic [1:0] tz_ost_en, tz_cbc_en, e1_ost_en, e2_cbc_en;
    logic [1:0] act_tz_a, act_e1_a, act_e2_a, act_tz_b, act_e1_b, act_e2_b;
    logic pwm_a_out, pwm_a_oe, pwm_b_out, pwm_b_oe, trip_ost, trip_cbc, flg_ost, flg_cbc;
    logic [3:0] flg_evt;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    pwm_trip_override dut_i (.*);

    // vector: {cmp0, tz1, pwm_a, act_e1_a[2], act_e2_a[2], exp_out, exp_oe}
    localparam logic [8:0] VEC [8] = '{
        9'b1_1_1_01_10_1_1,
        9'b1_1_0_01_10_0_1,
        9'b0_1_0_01_10_1_1,
        9'b0_0_1_10_01_0_1,
        9'b0_0_0_11_01_1_1,
        9'b1_0_1_01_00_0_0,
        9'b0_0_1_00_01_0_0,
        9'b0_0_1_11_11_1_1
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic cfg_default();
        pwm_a_in = 0; pwm_b_in = 0; cnt_zero = 0; osht_clr = 0; flag_clr = 0;
        tz_in = 2'b00; cmp_in = 2'b11;
        dca_hi_sel = 0; dca_lo_sel = 0; dcb_hi_sel = 0; dcb_lo_sel = 0;
        evt_cond = 8'h00; evt_async = 4'hF;
        tz_ost_en = 0; tz_cbc_en = 0; e1_ost_en = 0; e2_cbc_en = 0;
        act_tz_a = 2'b11; act_e1_a = 2'b11; act_e2_a = 2'b11;
        act_tz_b = 2'b11; act_e1_b = 2'b11; act_e2_b = 2'b11;
    endtask

    task automatic do_reset();
        cfg_default();
        rst_n = 0;
        step(); step();
        rst_n = 1;
        step();
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R1 reset state
        pwm_a_in = 1; pwm_b_in = 0; #1;
        chk("R1 trip_ost", trip_ost, 0);
        chk("R1 trip_cbc", trip_cbc, 0);
        chk("R1 flags", {flg_ost, flg_cbc, flg_evt}, 0);
        chk("R1 pass A", {pwm_a_out, pwm_a_oe}, 2'b11);
        chk("R1 pass B", {pwm_b_out, pwm_b_oe}, 2'b01);

        // R2 R3 R4 ladder table, A high=cmp0 (sel 2), A low=tz1 (sel 1)
        dca_hi_sel = 2; dca_lo_sel = 1;
        evt_cond = 8'b00_00_11_01;
        for (int i = 0; i < 8; i++) begin
            step();
            cmp_in[0] = VEC[i][8]; tz_in[1] = VEC[i][7]; pwm_a_in = VEC[i][6];
            act_e1_a = VEC[i][5:4]; act_e2_a = VEC[i][3:2];
            #2;
            chk($sformatf("R4 R2 vec%0d", i), {pwm_a_out, pwm_a_oe}, VEC[i][1:0]);
        end

        // R7 R4 one-shot from tz0, trip beats event 1
        do_reset();
        dca_hi_sel = 2; evt_cond = 8'b00_00_00_01; cmp_in[0] = 0;
        tz_ost_en = 2'b01; act_tz_a = 2'b10; act_e1_a = 2'b01; act_tz_b = 2'b00;
        pwm_b_in = 1;
        step(); tz_in[0] = 1; #2;
        chk("R4 trip over evt1", {pwm_a_out, pwm_a_oe}, 2'b01);
        chk("R5 B hiz by trip", {pwm_b_out, pwm_b_oe}, 2'b00);
        step(); tz_in[0] = 0; #2;
        chk("R7 ost latched", trip_ost, 1);
        chk("R7 held action", {pwm_a_out, pwm_a_oe}, 2'b01);
        step(); step(); #2;
        chk("R7 still held", trip_ost, 1);
        chk("R10 flg_ost", flg_ost, 1);
        step(); osht_clr = 1; #2;
        chk("R7 clear not yet", trip_ost, 1);
        step(); osht_clr = 0; #2;
        chk("R7 cleared", trip_ost, 0);
        chk("R4 evt1 after clear", {pwm_a_out, pwm_a_oe}, 2'b11);
        step(); flag_clr = 1;
        step(); flag_clr = 0; #2;
        chk("R10 flg_ost cleared", flg_ost, 0);
        chk("R10 evt flag kept", flg_evt[0], 1);
        cmp_in[0] = 1;
        step(); step(); flag_clr = 1;
        step(); flag_clr = 0; #2;
        chk("R10 evt flag cleared", flg_evt[0], 0);

        // R8 cycle-by-cycle
        do_reset();
        tz_cbc_en = 2'b01; act_tz_a = 2'b01;
        step(); tz_in[0] = 1;
        step(); tz_in[0] = 0; #2;
        chk("R8 cbc set", trip_cbc, 1);
        chk("R8 cbc action", {pwm_a_out, pwm_a_oe}, 2'b11);
        step(); cnt_zero = 1; tz_in[0] = 1;
        step(); cnt_zero = 0; #2;
        chk("R8 kept at zero with src", trip_cbc, 1);
        step(); tz_in[0] = 0;
        step(); step(); #2;
        chk("R8 kept without zero", trip_cbc, 1);
        step(); cnt_zero = 1; #2;
        chk("R8 before zero edge", trip_cbc, 1);
        step(); cnt_zero = 0; #2;
        chk("R8 released", trip_cbc, 0);
        chk("R8 pass after release", {pwm_a_out, pwm_a_oe}, 2'b01);
        chk("R10 flg_cbc", flg_cbc, 1);

        // R6 synchronized path
        do_reset();
        dca_hi_sel = 2; evt_cond = 8'b00_00_00_01; evt_async = 4'b1110;
        act_e1_a = 2'b01;
        step(); cmp_in[0] = 0; #2;
        chk("R6 sync not yet", {pwm_a_out, pwm_a_oe}, 2'b01);
        step(); #2;
        chk("R6 sync after edge", {pwm_a_out, pwm_a_oe}, 2'b11);
        evt_async = 4'b1111; step(); cmp_in[0] = 1; #2;
        chk("R6 async immediate", {pwm_a_out, pwm_a_oe}, 2'b01);

        // R9 routing independent of action
        do_reset();
        dca_hi_sel = 2; evt_cond = 8'b00_00_00_01; e1_ost_en = 2'b01;
        pwm_a_in = 1;
        step(); cmp_in[0] = 0; #2;
        chk("R9 routed no action", {pwm_a_out, pwm_a_oe}, 2'b11);
        step(); cmp_in[0] = 1; #2;
        chk("R9 evt1 to one-shot", trip_ost, 1);
        chk("R9 cbc untouched", trip_cbc, 0);

        // R5 R3 R9 output B: event1 on cmp1 high, event2 on tz1 low to cbc
        do_reset();
        tz_in[1] = 1; dcb_hi_sel = 3; dcb_lo_sel = 1;
        evt_cond = 8'b11_10_00_00; act_e1_b = 2'b10; e2_cbc_en = 2'b10;
        pwm_b_in = 1; cmp_in[1] = 0;
        step(); #2;
        chk("R5 B pass", {pwm_b_out, pwm_b_oe}, 2'b11);
        cmp_in[1] = 1; #1;
        chk("R5 B evt1 low", {pwm_b_out, pwm_b_oe}, 2'b01);
        chk("R9 A unaffected", {pwm_a_out, pwm_a_oe}, 2'b01);
        step(); tz_in[1] = 0;
        step(); tz_in[1] = 1; #2;
        chk("R9 evt2 B to cbc", trip_cbc, 1);
        chk("R9 evt2 B not ost", trip_ost, 0);
        chk("R10 evt flags B", flg_evt[3:2], 2'b11);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule